// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block takes one instruction word together with the address it was fetched from and a snapshot of the four status flags (negative, zero, carry, overflow). It recognises whether the word is a relative jump, evaluates the jump's condition against the flags, and produces the address of the next instruction. If the jump is taken, that address is the target. Otherwise it is the address of the following word. The block only reads the flags and has no path that could change them.

Requests arrive on a valid/ready input stream and results leave on a valid/ready output stream, through a single register stage. An input transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the block can accept one request per cycle as long as the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted.

Top module: `rel_jump_unit`

## Requirements
- R1: A word is a jump when bits [15:13] equal 3'b001. `out_is_jump` reports this for the accepted word.
- R2: For a jump, the 3-bit condition in bits [12:10] selects the test that drives `out_taken`:
  - 0: Z=0
  - 1: Z=1
  - 2: C=0
  - 3: C=1
  - 4: N=1
  - 5: N==V
  - 6: N!=V
  - 7: always
- R3: For a taken jump, `out_next_pc` equals the jump address plus 2 plus twice the sign-extended 10-bit offset in bits [9:0], modulo 2^16.
- R4: For a jump whose condition fails, `out_next_pc` equals the jump address plus 2.
- R5: For a word that is not a jump, `out_is_jump` and `out_taken` are 0 and `out_next_pc` equals the address plus 2.
- R6: Bit 0 of `in_pc` is treated as 0, so bit 0 of `out_next_pc` is always 0.
- R7: Handshake rules:
  - `in_ready` equals `!out_valid || out_ready`.
  - An accepted request produces `out_valid` on the next cycle.
  - Results leave in acceptance order.
  - A result that is valid but not ready stays stable.
- R8: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R9: Word 0x2FE4 tests C=1 and carries an offset of -28 words. When C=1 its target is the address plus 2 minus 56.
- R10: The offset extremes are handled. Offset 0x1FF adds 1022 bytes and offset 0x200 subtracts 1024 bytes, both before the fixed +2 is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_instr | input | 16 | Instruction word |
| in_pc | input | 16 | Address of the instruction word |
| in_flag_n | input | 1 | Negative flag |
| in_flag_z | input | 1 | Zero flag |
| in_flag_c | input | 1 | Carry flag |
| in_flag_v | input | 1 | Overflow flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_is_jump | output | 1 | Accepted word was a jump |
| out_taken | output | 1 | Jump condition held |
| out_next_pc | output | 16 | Address of the next instruction |

## Verification
The hardest situation to reach from the ports is a stalled result combined with a waiting request. In that case the output must stay frozen while a new word sits at the input, and acceptance must resume in the same cycle the consumer drains the stage. The stimulus reaches this case by dropping `out_ready` at random on about a quarter of the cycles while requests are offered back to back. Every condition code is also swept against all sixteen flag combinations. The offset extremes, odd addresses and addresses near the wrap point are applied as directed words.

// File: rtl/rjmp_pkg.sv
package rjmp_pkg;
  localparam int INSTR_W = 16;
  localparam int OFF_W   = 10;
  localparam int COND_W  = 3;
  localparam int GRP_W   = 3;
  localparam logic [GRP_W-1:0] JMP_GROUP = 3'b001;
  localparam int NUM_COND = 1 << COND_W;

  typedef enum logic [COND_W-1:0] {
    CC_NE     = 3'd0,
    CC_EQ     = 3'd1,
    CC_NC     = 3'd2,
    CC_CS     = 3'd3,
    CC_NEG    = 3'd4,
    CC_GE     = 3'd5,
    CC_LT     = 3'd6,
    CC_ALWAYS = 3'd7
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/rjmp_decode.sv
module rjmp_decode
  import rjmp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               is_jump,
  output cond_e              cond,
  output logic [OFF_W-1:0]   offset
);
  localparam int GRP_LSB  = INSTR_W - GRP_W;
  localparam int COND_LSB = OFF_W;

  always_comb begin
    is_jump = (instr[INSTR_W-1:GRP_LSB] == JMP_GROUP);
    cond    = cond_e'(instr[COND_LSB+COND_W-1:COND_LSB]);
    offset  = instr[OFF_W-1:0];
  end
endmodule

// File: rtl/rjmp_cond_eval.sv
module rjmp_cond_eval
  import rjmp_pkg::*;
(
  input  cond_e  cond,
  input  flags_t flags,
  output logic   pass
);
  logic [NUM_COND-1:0] test;
  logic [NUM_COND-1:0] hit;

  always_comb begin
    test[CC_NE]     = ~flags.z;
    test[CC_EQ]     =  flags.z;
    test[CC_NC]     = ~flags.c;
    test[CC_CS]     =  flags.c;
    test[CC_NEG]    =  flags.n;
    test[CC_GE]     = ~(flags.n ^ flags.v);
    test[CC_LT]     =  (flags.n ^ flags.v);
    test[CC_ALWAYS] = 1'b1;
  end

  for (genvar gi = 0; gi < NUM_COND; gi++) begin : g_hit
    assign hit[gi] = (cond == cond_e'(gi)) & test[gi];
  end

  assign pass = |hit;
endmodule

// File: rtl/rjmp_target.sv
module rjmp_target
  import rjmp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic              take,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] LSB_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sext;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    base    = (pc & LSB_MASK) + STEP;
    sext    = {{EXT_W{offset[OFF_W-1]}}, offset};
    disp    = take ? (sext << 1) : '0;
    next_pc = base + disp;
  end
endmodule

// File: rtl/rel_jump_unit.sv
module rel_jump_unit
  import rjmp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_instr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_flag_n,
  input  logic              in_flag_z,
  input  logic              in_flag_c,
  input  logic              in_flag_v,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_jump,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_next_pc
);
  logic             dec_jump;
  cond_e            dec_cond;
  logic [OFF_W-1:0] dec_off;
  logic             cond_ok;
  logic             take;
  logic [ADDR_W-1:0] tgt;
  flags_t           flags;
  logic             accept;

  assign flags = '{n: in_flag_n, z: in_flag_z, c: in_flag_c, v: in_flag_v};

  rjmp_decode u_dec (
    .instr   (in_instr),
    .is_jump (dec_jump),
    .cond    (dec_cond),
    .offset  (dec_off)
  );

  rjmp_cond_eval u_cond (
    .cond  (dec_cond),
    .flags (flags),
    .pass  (cond_ok)
  );

  assign take = dec_jump & cond_ok;

  rjmp_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc      (in_pc),
    .offset  (dec_off),
    .take    (take),
    .next_pc (tgt)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_is_jump <= 1'b0;
      out_taken   <= 1'b0;
      out_next_pc <= '0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_is_jump <= dec_jump;
        out_taken   <= take;
        out_next_pc <= tgt;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rel_jump_unit_chk.sv
module rel_jump_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       in_instr,
  input logic [ADDR_W-1:0] in_pc,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_jump,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_next_pc
);
  localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc)
      && $stable(out_taken) && $stable(out_is_jump));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_taken_needs_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> out_is_jump);

  p_even_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_next_pc[0]);

  p_nonjump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_instr[15:13] != 3'b001 |=>
      !out_is_jump && !out_taken
      && out_next_pc == (($past(in_pc) & MASK) + TWO));

  p_always_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_instr[15:10] == 6'b001111 && in_instr[9:0] == 10'd0 |=>
      out_taken && out_next_pc == (($past(in_pc) & MASK) + TWO));
endmodule

bind rel_jump_unit rel_jump_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .in_pc       (in_pc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_is_jump (out_is_jump),
  .out_taken   (out_taken),
  .out_next_pc (out_next_pc)
);

// File: tb/rel_jump_unit_tb.sv
`timescale 1ns/1ps
module rel_jump_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [15:0] in_pc = '0;
  logic        in_flag_n = 1'b0, in_flag_z = 1'b0, in_flag_c = 1'b0, in_flag_v = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_is_jump;
  logic        out_taken;
  logic [15:0] out_next_pc;

  always #2.5 clk = ~clk;

  rel_jump_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc),
    .in_flag_n(in_flag_n), .in_flag_z(in_flag_z),
    .in_flag_c(in_flag_c), .in_flag_v(in_flag_v),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_is_jump(out_is_jump), .out_taken(out_taken),
    .out_next_pc(out_next_pc)
  );

  typedef struct {
    logic        is_jump;
    logic        taken;
    logic [15:0] next_pc;
    string       tag;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     fails = 0;
  int     cycles = 0;
  logic   drain = 1'b0;
  logic   nx_valid = 1'b0;
  logic [15:0] nx_instr = '0, nx_pc = '0;
  logic [3:0]  nx_flags = '0;
  logic   last_fire_in;
  logic   held_v = 1'b0;
  logic   held_j, held_t;
  logic [15:0] held_pc;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ref_cond(input logic [2:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic exp_t ref_model(input logic [15:0] ins, input logic [15:0] pc,
                                     input logic [3:0] f, input string tag);
    exp_t e;
    integer off, addr;
    e.is_jump = (ins[15:13] == 3'b001);
    e.taken   = e.is_jump && ref_cond(ins[12:10], f);
    off  = int'(ins[9:0]);
    if (off >= 512) off = off - 1024;
    addr = int'(pc) - (int'(pc) % 2) + 2 + (e.taken ? 2 * off : 0);
    e.next_pc = 16'(addr);
    if (tag != "") e.tag = tag;
    else if (!e.is_jump) e.tag = "R5";
    else if (e.taken) e.tag = "R3";
    else e.tag = "R4";
    return e;
  endfunction

  // one clock: apply staged inputs at the falling edge, sample, then update the model
  task automatic step(input string tag);
    logic fi, fo, rdy_exp;
    logic cj, ct;
    logic [15:0] cpc;
    @(negedge clk);
    in_valid  = nx_valid;
    in_instr  = nx_instr;
    in_pc     = nx_pc;
    {in_flag_n, in_flag_z, in_flag_c, in_flag_v} = nx_flags;
    out_ready = drain ? 1'b1 : (($urandom % 4) != 0);
    #1;
    rdy_exp = !out_valid || out_ready;
    check("R7 in_ready", {15'd0, in_ready}, {15'd0, rdy_exp});
    if (held_v) begin
      check("R7 hold valid", {15'd0, out_valid}, 16'd1);
      check("R7 hold pc", out_next_pc, held_pc);
      check("R7 hold flags", {14'd0, out_is_jump, out_taken}, {14'd0, held_j, held_t});
    end
    fi  = in_valid && in_ready;
    fo  = out_valid && out_ready;
    cj  = out_is_jump; ct = out_taken; cpc = out_next_pc;
    held_v  = out_valid && !out_ready;
    held_j  = cj; held_t = ct; held_pc = cpc;
    @(posedge clk);
    if (fo) begin
      if (q.size() == 0) begin
        fails++; checks++;
        $display("FAIL R7: actual unexpected result expected none");
      end else begin
        exp_t e = q.pop_front();
        check("R1 is_jump", {15'd0, cj}, {15'd0, e.is_jump});
        check("R2 taken", {15'd0, ct}, {15'd0, e.taken});
        check({e.tag, " next_pc"}, cpc, e.next_pc);
      end
    end
    if (fi) q.push_back(ref_model(in_instr, in_pc, {in_flag_n, in_flag_z, in_flag_c, in_flag_v}, tag));
    last_fire_in = fi;
  endtask

  task automatic send(input logic [15:0] ins, input logic [15:0] pc,
                      input logic [3:0] f, input string tag);
    nx_valid = 1'b1; nx_instr = ins; nx_pc = pc; nx_flags = f;
    do step(tag); while (!last_fire_in);
    nx_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R8 in_ready in reset", {15'd0, in_ready}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: worked example, carry set then clear
    send(16'h2FE4, 16'h8100, 4'b0010, "R9");
    send(16'h2FE4, 16'h8100, 4'b0000, "R4");
    // R10: offset extremes
    send(16'h3DFF, 16'h4000, 4'b0000, "R10");
    send(16'h3E00, 16'h4000, 4'b0000, "R10");
    // R6: odd address, taken and not taken
    send(16'h3C05, 16'h1235, 4'b0000, "R6");
    send(16'h0000, 16'h7FFF, 4'b0000, "R6");
    // R3: wrap at top and bottom of the address space
    send(16'h3C10, 16'hFFF0, 4'b0000, "R3");
    send(16'h3E00, 16'h0010, 4'b0000, "R3");
    // R5: words from other groups
    send(16'h4504, 16'h2000, 4'b1111, "R5");
    send(16'h1005, 16'h2002, 4'b1111, "R5");
    send(16'hFFFF, 16'hFFFE, 4'b1111, "R5");
    // R2: every condition against every flag pattern
    for (int cc = 0; cc < 8; cc++)
      for (int f = 0; f < 16; f++)
        send({3'b001, 3'(cc), 10'($urandom)}, 16'($urandom), 4'(f), "");
    // R7: random traffic under back-pressure
    for (int k = 0; k < 300; k++)
      send(16'($urandom), 16'($urandom), 4'($urandom), "");
    drain = 1'b1;
    while (q.size() != 0 || out_valid) step("");
    check("R7 queue empty", 16'(q.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule